// File: doc/BRIEF.md
# System performance monitor control bank

This block holds the main control register for a set of system performance monitor instances. Each instance also has a small bank of event counters. A selector register holds an instance index. A 64-bit control write then goes to the chosen instance, and a read returns that instance's control register. The selected instance's value appears on the read port in the cycle after the selector is written.

Each instance has the following behaviour:

- A count-enable bit gates its counters.
- A write-only strobe clears all of its counters together.
- Optional trace, halt, freeze and export bits exist only when a per-instance capability input allows them.
- A read-only "not accessible" status bit is shown only when its capability bit is set.
- Counters that wrap set sticky overflow flags.
- With freeze enabled, an overflow stops that instance's counters and no other instance's.
- An enabled instance with any flag set raises its interrupt line.

Top module: `sysmon_ctrl_bank`

## Requirements
- R1: A counter counts one per cycle in which its event input is high, but only while its instance's enable (control bit 0) is 1.
- R2: Writing a value with bit 1 set clears every counter of the selected instance at that clock edge; bit 1 always reads as 0.
- R3: Clearing counters through bit 1 leaves every overflow flag unchanged.
- R4: An instance's interrupt is high exactly when its enable is 1 and at least one of its overflow flags is set.
- R5: The capability input gives five bits per instance, from MSB to LSB: trace, halt, freeze, not-accessible, export. Control bits 11 (trace), 10 (halt), 9 (freeze) and 4 (export) store written values only when the matching capability bit is 1; otherwise they read 0.
- R6: Bit 8 shows the instance's not-accessible status input when its capability bit is 1, reads 0 otherwise, and is never changed by writes.
- R7: While an instance has freeze set and any of its flags is set, its counters hold, and other instances keep counting.
- R8: Bits 63:12, 7:5 and 3:2 always read 0.
- R9: The read port shows the control register of the instance named by the selector; an index at or above the number of implemented instances reads 0 and ignores writes.
- R10: A counter wrapping from all ones to zero sets its sticky overflow flag; a pulse on that flag's clear input clears it, and a wrap in the same cycle wins.
- R11: When a clear write and an event for the same counter fall in one cycle, the counter becomes 0 and no overflow flag is set.
- R12: After reset, all control bits, the selector, counters and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Load the selector |
| sel_wr_data | input | SEL_W | New selector index |
| reg_wr_en | input | 1 | Write the selected control register |
| reg_wr_data | input | 64 | Control write value |
| rd_data | output | 64 | Control register of the selected instance |
| cap_cfg | input | NUM_INST*5 | Capability bits per instance |
| na_status | input | NUM_INST | Not-accessible status per instance |
| evt | input | NUM_INST*NUM_CTR | Event pulses, bit i*NUM_CTR+k for counter k of instance i |
| ovf_clr | input | NUM_INST*NUM_CTR | Overflow flag clear pulses, same numbering |
| ctr_val | output | NUM_INST*NUM_CTR*CTR_W | Counter values, same numbering |
| ovf_flag | output | NUM_INST*NUM_CTR | Sticky overflow flags |
| irq | output | NUM_INST | Overflow interrupt per instance |

## Verification
A software counter clear and a hardware event can reach the same counter on the same edge. The bench provokes this with the counter one step from wrapping. The write with bit 1 set is driven together with the event pulse. The bench expects the counter to read zero, with no new overflow flag and the flags of other instances unchanged. An instance frozen by its own overflow is also run alongside an unfrozen one, with events to both in the same cycles.

// File: rtl/sysmon_pkg.sv
package sysmon_pkg;

    localparam int REG_W    = 64;
    localparam int BIT_EN   = 0;
    localparam int BIT_CLR  = 1;
    localparam int BIT_EXP  = 4;
    localparam int BIT_NA   = 8;
    localparam int BIT_FRZ  = 9;
    localparam int BIT_HALT = 10;
    localparam int BIT_TRC  = 11;

    // capability bits for one instance, MSB first
    typedef struct packed {
        logic trc;
        logic halt;
        logic frz;
        logic na;
        logic exp;
    } cap_t;

    localparam int CAP_W = $bits(cap_t);

    // stored control state for one instance
    typedef struct packed {
        logic en;
        logic exp;
        logic frz;
        logic halt;
        logic trc;
    } ctl_t;

endpackage

// File: rtl/sysmon_inst_ctl.sv
module sysmon_inst_ctl
    import sysmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  cap_t             cap,
    input  logic             na_src,
    output logic             en,
    output logic             frz,
    output logic             clr_pulse,
    output logic [REG_W-1:0] rd_val
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.en   = wr_data[BIT_EN];
            ctl_d.exp  = cap.exp  & wr_data[BIT_EXP];
            ctl_d.frz  = cap.frz  & wr_data[BIT_FRZ];
            ctl_d.halt = cap.halt & wr_data[BIT_HALT];
            ctl_d.trc  = cap.trc  & wr_data[BIT_TRC];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // the clear strobe is never stored; it acts on the same edge as the write
    assign clr_pulse = wr_en & wr_data[BIT_CLR];
    assign en        = ctl_q.en;
    assign frz       = ctl_q.frz & cap.frz;

    always_comb begin
        rd_val           = '0;
        rd_val[BIT_EN]   = ctl_q.en;
        rd_val[BIT_EXP]  = ctl_q.exp  & cap.exp;
        rd_val[BIT_NA]   = na_src     & cap.na;
        rd_val[BIT_FRZ]  = ctl_q.frz  & cap.frz;
        rd_val[BIT_HALT] = ctl_q.halt & cap.halt;
        rd_val[BIT_TRC]  = ctl_q.trc  & cap.trc;
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:12], wr_data[7:5], wr_data[3:2], wr_data[BIT_NA]};

endmodule

// File: rtl/sysmon_ctr_bank.sv
module sysmon_ctr_bank #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     frz,
    input  logic                     clr,
    input  logic [NUM_CTR-1:0]       evt,
    input  logic [NUM_CTR-1:0]       flag_clr,
    output logic [NUM_CTR*CTR_W-1:0] cnt,
    output logic [NUM_CTR-1:0]       ovf,
    output logic                     irq
);

    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    typedef struct packed {
        logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
        logic [NUM_CTR-1:0]            ovf;
    } bank_t;

    bank_t bank_d, bank_q;

    logic              frozen;
    logic              cnt_ok;
    logic [NUM_CTR-1:0] inc_v;
    logic [NUM_CTR-1:0] wrap_v;

    assign frozen = frz & (|bank_q.ovf);
    assign cnt_ok = en & ~frozen & ~clr;

    always_comb begin
        inc_v = evt & {NUM_CTR{cnt_ok}};
        for (int k = 0; k < NUM_CTR; k++) begin
            wrap_v[k] = inc_v[k] && (bank_q.cnt[k] == CTR_MAX);
        end
    end

    always_comb begin
        bank_d = bank_q;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (clr)           bank_d.cnt[k] = '0;
            else if (inc_v[k]) bank_d.cnt[k] = bank_q.cnt[k] + 1'b1;
            bank_d.ovf[k] = (bank_q.ovf[k] & ~flag_clr[k]) | wrap_v[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cnt = bank_q.cnt;
    assign ovf = bank_q.ovf;
    assign irq = en & (|bank_q.ovf);

endmodule

// File: rtl/sysmon_ctrl_bank.sv
module sysmon_ctrl_bank
    import sysmon_pkg::*;
#(
    parameter int NUM_INST  = 4,
    parameter int IMPL_INST = 3,
    parameter int NUM_CTR   = 4,
    parameter int CTR_W     = 16,
    parameter int SEL_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sel_wr_en,
    input  logic [SEL_W-1:0]                    sel_wr_data,
    input  logic                                reg_wr_en,
    input  logic [63:0]                         reg_wr_data,
    output logic [63:0]                         rd_data,
    input  logic [NUM_INST*5-1:0]               cap_cfg,
    input  logic [NUM_INST-1:0]                 na_status,
    input  logic [NUM_INST*NUM_CTR-1:0]         evt,
    input  logic [NUM_INST*NUM_CTR-1:0]         ovf_clr,
    output logic [NUM_INST*NUM_CTR*CTR_W-1:0]   ctr_val,
    output logic [NUM_INST*NUM_CTR-1:0]         ovf_flag,
    output logic [NUM_INST-1:0]                 irq
);

    localparam int BANK_CW = NUM_CTR * CTR_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [REG_W-1:0]    inst_rd [NUM_INST];
    logic [NUM_INST-1:0] inst_en;

    always_comb begin
        top_d = top_q;
        if (sel_wr_en) top_d.sel = sel_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
        if (gi < IMPL_INST) begin : g_impl
            logic wr_hit;
            logic frz;
            logic clr;
            cap_t cap;

            assign wr_hit = reg_wr_en && (top_q.sel == SEL_W'(gi));
            assign cap    = cap_t'(cap_cfg[gi*CAP_W +: CAP_W]);

            sysmon_inst_ctl u_ctl (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_hit),
                .wr_data   (reg_wr_data),
                .cap       (cap),
                .na_src    (na_status[gi]),
                .en        (inst_en[gi]),
                .frz       (frz),
                .clr_pulse (clr),
                .rd_val    (inst_rd[gi])
            );

            sysmon_ctr_bank #(
                .NUM_CTR (NUM_CTR),
                .CTR_W   (CTR_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (inst_en[gi]),
                .frz      (frz),
                .clr      (clr),
                .evt      (evt[gi*NUM_CTR +: NUM_CTR]),
                .flag_clr (ovf_clr[gi*NUM_CTR +: NUM_CTR]),
                .cnt      (ctr_val[gi*BANK_CW +: BANK_CW]),
                .ovf      (ovf_flag[gi*NUM_CTR +: NUM_CTR]),
                .irq      (irq[gi])
            );
        end else begin : g_absent
            assign inst_en[gi]                      = 1'b0;
            assign inst_rd[gi]                      = '0;
            assign ctr_val[gi*BANK_CW +: BANK_CW]   = '0;
            assign ovf_flag[gi*NUM_CTR +: NUM_CTR]  = '0;
            assign irq[gi]                          = 1'b0;

            logic unused_absent;
            assign unused_absent = ^{evt[gi*NUM_CTR +: NUM_CTR], ovf_clr[gi*NUM_CTR +: NUM_CTR],
                                     cap_cfg[gi*CAP_W +: CAP_W], na_status[gi]};
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (top_q.sel == SEL_W'(i)) rd_data = inst_rd[i];
        end
    end

endmodule

// File: rtl/sysmon_ctrl_chk.sv
module sysmon_ctrl_chk #(
    parameter int NUM_INST  = 4,
    parameter int IMPL_INST = 3,
    parameter int NUM_CTR   = 4,
    parameter int CTR_W     = 16,
    parameter int SEL_W     = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [SEL_W-1:0]                  sel_idx,
    input logic                              reg_wr_en,
    input logic [63:0]                       reg_wr_data,
    input logic [63:0]                       rd_data,
    input logic [NUM_INST-1:0]               irq,
    input logic [NUM_INST-1:0]               inst_en,
    input logic [NUM_INST*NUM_CTR-1:0]       ovf_clr,
    input logic [NUM_INST*NUM_CTR-1:0]       ovf_flag,
    input logic [NUM_INST*NUM_CTR*CTR_W-1:0] ctr_val
);

    localparam int BANK_CW = NUM_CTR * CTR_W;

    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~inst_en) == '0);

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[63:12] == '0) && (rd_data[7:5] == '0) && (rd_data[3:1] == '0));

    p_unimpl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_idx) >= IMPL_INST) |-> (rd_data == '0));

    // R3 and R10: without a flag-clear pulse no flag ever drops
    p_flags_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr == '0) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

    for (genvar gi = 0; gi < IMPL_INST; gi++) begin : g_clr
        p_clear_zeroes_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && (sel_idx == SEL_W'(gi)) && reg_wr_data[1])
            |=> (ctr_val[gi*BANK_CW +: BANK_CW] == '0));
    end

endmodule

bind sysmon_ctrl_bank sysmon_ctrl_chk #(
    .NUM_INST  (NUM_INST),
    .IMPL_INST (IMPL_INST),
    .NUM_CTR   (NUM_CTR),
    .CTR_W     (CTR_W),
    .SEL_W     (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_idx     (top_q.sel),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .rd_data     (rd_data),
    .irq         (irq),
    .inst_en     (inst_en),
    .ovf_clr     (ovf_clr),
    .ovf_flag    (ovf_flag),
    .ctr_val     (ctr_val)
);

// File: tb/sysmon_ctrl_bank_tb_top.sv
module sysmon_ctrl_bank_tb_top;

    localparam int NUM_INST  = 4;
    localparam int IMPL_INST = 3;
    localparam int NUM_CTR   = 2;
    localparam int CTR_W     = 4;
    localparam int SEL_W     = 3;
    localparam int EV_W      = NUM_INST * NUM_CTR;

    localparam int K_RD  = 0;
    localparam int K_CTR = 1;
    localparam int K_OVF = 2;
    localparam int K_IRQ = 3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     sel_wr_en = 1'b0;
    logic [SEL_W-1:0]         sel_wr_data = '0;
    logic                     reg_wr_en = 1'b0;
    logic [63:0]              reg_wr_data = '0;
    logic [63:0]              rd_data;
    logic [NUM_INST*5-1:0]    cap_cfg;
    logic [NUM_INST-1:0]      na_status = '1;
    logic [EV_W-1:0]          evt = '0;
    logic [EV_W-1:0]          ovf_clr = '0;
    logic [EV_W*CTR_W-1:0]    ctr_val;
    logic [EV_W-1:0]          ovf_flag;
    logic [NUM_INST-1:0]      irq;

    // inst0 all capabilities, inst1 none, inst2 freeze only
    assign cap_cfg = {5'b00000, 5'b00100, 5'b00000, 5'b11111};

    always #10 clk = ~clk;

    sysmon_ctrl_bank #(
        .NUM_INST  (NUM_INST),
        .IMPL_INST (IMPL_INST),
        .NUM_CTR   (NUM_CTR),
        .CTR_W     (CTR_W),
        .SEL_W     (SEL_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .rd_data     (rd_data),
        .cap_cfg     (cap_cfg),
        .na_status   (na_status),
        .evt         (evt),
        .ovf_clr     (ovf_clr),
        .ctr_val     (ctr_val),
        .ovf_flag    (ovf_flag),
        .irq         (irq)
    );

    typedef struct {
        int          kind;
        int          idx;
        logic [63:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        cur;
    logic [63:0] act;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    task automatic expect_item(int kind, int idx, logic [63:0] val, string tag);
        exp_t e;
        e.kind = kind;
        e.idx  = idx;
        e.val  = val;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares queued expectations 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                case (cur.kind)
                    K_RD:    act = rd_data;
                    K_CTR:   act = 64'(ctr_val[cur.idx*CTR_W +: CTR_W]);
                    K_OVF:   act = 64'(ovf_flag);
                    default: act = 64'(irq);
                endcase
                n_cmp++;
                if (act !== cur.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", cur.tag, act, cur.val);
                end
            end
        end
    end

    task automatic sel_write(int s);
        @(negedge clk);
        sel_wr_en   = 1'b1;
        sel_wr_data = SEL_W'(s);
        @(negedge clk);
        sel_wr_en   = 1'b0;
    endtask

    task automatic reg_write(logic [63:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic run_evt(logic [EV_W-1:0] mask, int n);
        @(negedge clk);
        evt = mask;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic pulse_clr(logic [EV_W-1:0] mask);
        @(negedge clk);
        ovf_clr = mask;
        @(negedge clk);
        ovf_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state; inst0 shows its not-accessible status (R6)
        expect_item(K_RD, 0, 64'h100, "R12 reset read inst0");
        expect_item(K_OVF, 0, 64'h0, "R12 reset flags");
        expect_item(K_IRQ, 0, 64'h0, "R12 reset irq");
        expect_item(K_CTR, 2, 64'h0, "R12 reset counter");
        @(negedge clk);

        reg_write('1);
        expect_item(K_RD, 0, 64'hF11, "R5 R8 R2 all-ones write inst0");
        reg_write(64'h0);
        expect_item(K_RD, 0, 64'h100, "R6 not-accessible bit ignores write");

        sel_write(1);
        reg_write('1);
        expect_item(K_RD, 0, 64'h001, "R5 R6 no capabilities inst1");

        sel_write(5);
        reg_write('1);
        expect_item(K_RD, 0, 64'h0, "R9 unimplemented index 5");
        sel_write(3);
        expect_item(K_RD, 0, 64'h0, "R9 unimplemented index 3");
        sel_write(1);
        expect_item(K_RD, 0, 64'h001, "R9 inst1 untouched");

        run_evt(8'h04, 3);
        expect_item(K_CTR, 2, 64'd3, "R1 enabled counts");
        run_evt(8'h10, 2);
        expect_item(K_CTR, 4, 64'd0, "R1 disabled holds");

        reg_write(64'h3);
        expect_item(K_CTR, 2, 64'd0, "R2 clear counters");
        expect_item(K_RD, 0, 64'h001, "R2 clear bit reads zero");

        run_evt(8'h08, 16);
        expect_item(K_CTR, 3, 64'd0, "R10 wrap value");
        expect_item(K_OVF, 0, 64'h08, "R10 flag set on wrap");
        expect_item(K_IRQ, 0, 64'h2, "R4 irq raised");

        reg_write(64'h3);
        expect_item(K_OVF, 0, 64'h08, "R3 clear keeps flag");
        reg_write(64'h0);
        expect_item(K_IRQ, 0, 64'h0, "R4 irq masked by enable");
        expect_item(K_OVF, 0, 64'h08, "R4 flag still set");
        pulse_clr(8'h08);
        expect_item(K_OVF, 0, 64'h0, "R10 flag clear input");
        reg_write(64'h1);

        sel_write(2);
        reg_write(64'h201);
        expect_item(K_RD, 0, 64'h201, "R5 freeze capability only");
        run_evt(8'h10, 16);
        expect_item(K_OVF, 0, 64'h10, "R10 inst2 overflow");
        expect_item(K_IRQ, 0, 64'h4, "R4 inst2 irq");
        run_evt(8'h24, 2);
        expect_item(K_CTR, 5, 64'd0, "R7 frozen instance holds");
        expect_item(K_CTR, 2, 64'd2, "R7 other instance counts");

        sel_write(1);
        run_evt(8'h04, 13);
        expect_item(K_CTR, 2, 64'd15, "R11 setup at max");
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = 64'h3;
        evt         = 8'h04;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
        evt         = '0;
        expect_item(K_CTR, 2, 64'd0, "R11 clear beats event");
        expect_item(K_OVF, 0, 64'h10, "R11 no overflow from dropped event");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule